// File: doc/BRIEF.md
# Mesh Vertex Sweep Sequencer

This block drives a microcoded vertex processor across a two-dimensional mesh. Software writes the mesh origin address and the last horizontal and last vertical coordinates, then sets the start bit. The sequencer runs the program once for every vertex. Rows are the outer loop and columns the inner loop, and both bounds are inclusive. For each vertex it presents the coordinates to the core, which loads them into its first two general registers. It then pulses a launch strobe so that the core restarts its program at address zero.

A vertex run ends when the core reports an output-vector instruction with two operands. The sequencer then issues a two-beat write over a valid/ready master to a slot on a 128-column grid. Each word goes out with its most significant byte first. If the core keeps stepping without ever producing output, a step guard aborts that vertex and the sweep moves on. When the last vertex is done, the sequencer records how many vertices the mesh holds, clears its busy flag and raises a one-cycle interrupt.

Top module: `mesh_sweep_seq`

## Requirements
- R1: Writing 1 to bit 0 of the control register (offset 0) while idle sets `busy` and launches the first vertex with `core_x`=0, `core_y`=0. Control reads return `busy` in bit 0.
- R2: Launches visit every x from 0 to the horizontal-last value (offset 2) for y=0, then for each later y up to the vertical-last value (offset 3), both bounds inclusive. `core_x` and `core_y` are valid while `core_start` is high.
- R3: On `core_vout` the block writes two beats. The first goes to base + 8*(128*y + x), where base is at offset 1, and carries `core_opa`. The second goes to that address + 4 and carries `core_opb`.
- R4: Every beat carries its operand byte-reversed: operand bits [7:0] appear in `wr_data[31:24]`, and operand bits [31:24] appear in `wr_data[7:0]`.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold steady. The next vertex is not launched until the second beat has been accepted.
- R6: After each accepted second beat, the last-write register (offset 5) holds that beat's address, which is the burst address + 4.
- R7: A vertex whose core reports a 2049th `core_step` without `core_vout` gets a one-cycle `core_abort`. That vertex issues no write, and the sweep goes on to the next vertex.
- R8: After the last vertex, the vertex-count register (offset 4) holds (hlast+1)*(vlast+1). `irq` is high for exactly one cycle, and `busy` is low from that cycle on.
- R9: A start write made while `busy` is set has no effect: the sweep keeps its order and launch count.
- R10: Synchronous reset clears `busy`, `irq`, `wr_valid`, the vertex-count register and the last-write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| busy | output | 1 | Sweep in progress |
| irq | output | 1 | One-cycle end-of-sweep pulse |
| core_start | output | 1 | Restart the program at address 0 for this vertex |
| core_x | output | 7 | Vertex column for general register 0 |
| core_y | output | 7 | Vertex row for general register 1 |
| core_abort | output | 1 | Runaway program aborted |
| core_step | input | 1 | Core executed one instruction |
| core_vout | input | 1 | Core issued the output-vector instruction |
| core_opa | input | 32 | First output operand |
| core_opb | input | 32 | Second output operand |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | 32 | Write beat address |
| wr_data | output | 32 | Write beat data, byte-reversed |

## Verification
The bench stalls the write port on an irregular pattern. A design that let the address or data drift during a stall, or launched the next vertex before the second beat was taken, would leave the scoreboard misaligned. One vertex runs away, and the bench counts the steps the core delivers before the abort. A guard that was off by one would abort at step 2048 or 2050, and a guard that still wrote something would leave an unexpected beat. A second start write in the middle of a sweep would restart at vertex (0,0) on a design that did not ignore it, which breaks the launch order. A one-vertex mesh checks the inclusive bounds and a vertex count of 1.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_RUN,
    ST_WRITE,
    ST_NEXT
  } seq_state_t;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_BASE   = 3'd1;
  localparam logic [2:0] RA_HLAST  = 3'd2;
  localparam logic [2:0] RA_VLAST  = 3'd3;
  localparam logic [2:0] RA_VCOUNT = 3'd4;
  localparam logic [2:0] RA_LASTWR = 3'd5;
endpackage

// File: rtl/mesh_walker.sv
module mesh_walker #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  input  logic [CW-1:0] h_last,
  input  logic [CW-1:0] v_last,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          at_end
);
  logic row_end;
  assign row_end = (x == h_last);
  assign at_end  = row_end && (y == v_last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      x <= '0;
      y <= '0;
    end else if (advance) begin
      if (row_end) begin
        x <= '0;
        y <= y + 1'b1;
      end else begin
        x <= x + 1'b1;
      end
    end
  end

  // R2: columns advance before rows
  assert_inner_first_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear && x != h_last) |=> (y == $past(y) && x == $past(x) + 1'b1));
endmodule

// File: rtl/step_guard.sv
module step_guard #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic trip
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  logic [CNT_W-1:0] cnt;

  assign trip = step && (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (step && !trip) cnt <= cnt + 1'b1;
  end

  // R7: the count never passes the limit
  assert_guard_cap_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LIMIT));
endmodule

// File: rtl/burst_writer.sv
module burst_writer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              done
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] swap_a, swap_b, held_b;
  logic              second;

  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign swap_a[8*i +: 8] = opa[DATA_W-8-8*i +: 8];
    assign swap_b[8*i +: 8] = opb[DATA_W-8-8*i +: 8];
  end

  assign done = valid && ready && second;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      second <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
      held_b <= '0;
    end else if (go) begin
      valid  <= 1'b1;
      second <= 1'b0;
      waddr  <= addr;
      wdata  <= swap_a;
      held_b <= swap_b;
    end else if (valid && ready) begin
      if (!second) begin
        second <= 1'b1;
        waddr  <= waddr + ADDR_W'(4);
        wdata  <= held_b;
      end else begin
        valid  <= 1'b0;
        second <= 1'b0;
      end
    end
  end

  // R5: a stalled beat holds its address and data
  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !go) |=> (valid && $stable(waddr) && $stable(wdata)));
endmodule

// File: rtl/mesh_sweep_seq.sv
module mesh_sweep_seq
  import mesh_seq_pkg::*;
#(
  parameter int GRID_LOG2 = 7,
  parameter int ADDR_W    = 32,
  parameter int MAX_STEPS = 2048
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output logic [WORD_W-1:0]    cfg_rdata,
  output logic                 busy,
  output logic                 irq,
  output logic                 core_start,
  output logic [GRID_LOG2-1:0] core_x,
  output logic [GRID_LOG2-1:0] core_y,
  output logic                 core_abort,
  input  logic                 core_step,
  input  logic                 core_vout,
  input  logic [WORD_W-1:0]    core_opa,
  input  logic [WORD_W-1:0]    core_opb,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data
);
  localparam int CW1   = GRID_LOG2 + 1;
  localparam int OFF_W = 2 * GRID_LOG2 + 3;

  seq_state_t          state;
  logic [ADDR_W-1:0]   base_q, lastwr_q;
  logic [GRID_LOG2-1:0] hlast_q, vlast_q;
  logic [2*CW1-1:0]    vcount_q;
  logic                busy_q, irq_q, start_q, abort_q;

  logic start_req, walk_clear, walk_adv, at_end;
  logic guard_clr, guard_step, trip;
  logic burst_go, burst_done;
  logic [OFF_W-1:0]  slot_off;
  logic [ADDR_W-1:0] burst_addr;
  logic [2*CW1-1:0]  vertex_total;

  assign start_req  = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[0] &&
                      !busy_q && (state == ST_IDLE);
  assign walk_clear = start_req;
  assign walk_adv   = (state == ST_NEXT) && !at_end;
  assign guard_clr  = (state == ST_LAUNCH);
  assign guard_step = (state == ST_RUN) && core_step && !core_vout;
  assign burst_go   = (state == ST_RUN) && core_vout;

  assign slot_off     = {core_y, core_x, 3'b000};
  assign burst_addr   = base_q + ADDR_W'(slot_off);
  assign vertex_total = (CW1'(hlast_q) + CW1'(1)) * (CW1'(vlast_q) + CW1'(1));

  mesh_walker #(.CW(GRID_LOG2)) walker_i (
    .clk(clk), .rst(rst), .clear(walk_clear), .advance(walk_adv),
    .h_last(hlast_q), .v_last(vlast_q),
    .x(core_x), .y(core_y), .at_end(at_end)
  );

  step_guard #(.LIMIT(MAX_STEPS)) guard_i (
    .clk(clk), .rst(rst), .clear(guard_clr), .step(guard_step), .trip(trip)
  );

  burst_writer #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) writer_i (
    .clk(clk), .rst(rst), .go(burst_go), .addr(burst_addr),
    .opa(core_opa), .opb(core_opb), .ready(wr_ready),
    .valid(wr_valid), .waddr(wr_addr), .wdata(wr_data), .done(burst_done)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      hlast_q <= '0;
      vlast_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_BASE:  base_q  <= cfg_wdata[ADDR_W-1:0];
        RA_HLAST: hlast_q <= cfg_wdata[GRID_LOG2-1:0];
        RA_VLAST: vlast_q <= cfg_wdata[GRID_LOG2-1:0];
        default: ;
      endcase
    end
  end

  // sweep control
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy_q   <= 1'b0;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
      abort_q  <= 1'b0;
      vcount_q <= '0;
      lastwr_q <= '0;
    end else begin
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            busy_q <= 1'b1;
            state  <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          start_q <= 1'b1;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          if (core_vout) begin
            state <= ST_WRITE;
          end else if (trip) begin
            abort_q <= 1'b1;
            state   <= ST_NEXT;
          end
        end
        ST_WRITE: begin
          if (burst_done) begin
            lastwr_q <= wr_addr;
            state    <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (at_end) begin
            vcount_q <= vertex_total;
            busy_q   <= 1'b0;
            irq_q    <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            state <= ST_LAUNCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        RA_CTRL:   cfg_rdata <= {{(WORD_W-1){1'b0}}, busy_q};
        RA_BASE:   cfg_rdata <= WORD_W'(base_q);
        RA_HLAST:  cfg_rdata <= WORD_W'(hlast_q);
        RA_VLAST:  cfg_rdata <= WORD_W'(vlast_q);
        RA_VCOUNT: cfg_rdata <= WORD_W'(vcount_q);
        RA_LASTWR: cfg_rdata <= WORD_W'(lastwr_q);
        default:   cfg_rdata <= '0;
      endcase
    end
  end

  assign busy       = busy_q;
  assign irq        = irq_q;
  assign core_start = start_q;
  assign core_abort = abort_q;

  // R8: the interrupt is a single-cycle pulse and the sweep is already idle
  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> !busy);
  // R5: no launch while a burst is still outstanding
  assert_launch_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    core_start |-> !wr_valid);
  // R7: an aborted vertex has no write in flight
  assert_abort_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
    core_abort |-> !wr_valid);
  // R6: the last-write register moves only on an accepted beat
  assert_lastwr_update_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lastwr_q) |-> $past(wr_valid && wr_ready));
endmodule

// File: tb/mesh_sweep_seq_tb_top.sv
module mesh_sweep_seq_tb_top;
  localparam int GUARD = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        busy, irq, core_start, core_abort;
  logic [6:0]  core_x, core_y;
  logic        core_step = 1'b0, core_vout = 1'b0;
  logic [31:0] core_opa = '0, core_opb = '0;
  logic        wr_valid, wr_ready = 1'b0;
  logic [31:0] wr_addr, wr_data;

  always #4 clk = ~clk;

  mesh_sweep_seq dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .irq(irq),
    .core_start(core_start), .core_x(core_x), .core_y(core_y),
    .core_abort(core_abort), .core_step(core_step), .core_vout(core_vout),
    .core_opa(core_opa), .core_opb(core_opb), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int tests = 0, fails = 0, cycles = 0;
  logic [63:0] exp_q[$];

  // sweep plan shared by the processes
  logic [31:0] base;
  int hl, vl, ex, ey, launches, runaway_idx, steps, plan;
  bit active, runaway, fast_ready;
  int rcnt = 0;
  bit stall_seen = 0;
  logic [31:0] stall_a, stall_d;

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver side: push the two beats a vertex should produce
  task automatic push_burst(input int x, input int y, input logic [31:0] a,
                            input logic [31:0] b);
    logic [31:0] ad;
    ad = base + 32'(8 * (128 * y + x));
    exp_q.push_back({ad, bswap(a)});
    exp_q.push_back({ad + 32'd4, bswap(b)});
  endtask

  // core model
  always @(negedge clk) begin
    core_step = 1'b0;
    core_vout = 1'b0;
    if (!rst) begin
      if (active) begin
        if (core_abort) begin
          active = 0;
          check(runaway, "R7 abort on runaway vertex only", 32'(runaway), 32'd1);
          check(steps == GUARD + 1, "R7 steps before abort", 32'(steps), 32'(GUARD + 1));
        end else if (steps < plan) begin
          core_step = 1'b1;
          steps++;
        end else begin
          core_opa = {8'h11, 8'(core_x), 8'(core_y), 8'hA5};
          core_opb = {8'h22, 8'(core_y), 8'(core_x), 8'h5A};
          core_vout = 1'b1;
          push_burst(int'(core_x), int'(core_y), core_opa, core_opb);
          active = 0;
        end
      end
      if (core_start) begin
        // R1 / R2: launch order and coordinates
        check(int'(core_x) == ex && int'(core_y) == ey, "R2 launch coordinates",
              {16'(core_y), 16'(core_x)}, {16'(ey), 16'(ex)});
        check(!wr_valid, "R5 launch after burst", 32'(wr_valid), 32'd0);
        runaway = (launches == runaway_idx);
        plan = runaway ? 1000000 : 3;
        steps = 0;
        active = 1;
        launches++;
        if (ex == hl) begin ex = 0; ey++; end else ex++;
      end
    end
  end

  // monitor side: pop and compare accepted beats
  always @(negedge clk) begin
    logic [63:0] e;
    if (!rst) begin
      if (stall_seen && wr_valid) begin
        check(wr_addr == stall_a && wr_data == stall_d, "R5 stalled beat stable",
              wr_addr, stall_a);
      end
      rcnt++;
      wr_ready = fast_ready ? 1'b1 : ((rcnt % 3) != 0);
      stall_seen = wr_valid && !wr_ready;
      stall_a = wr_addr;
      stall_d = wr_data;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 unexpected write beat", wr_addr, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(wr_addr == e[63:32], "R3 beat address", wr_addr, e[63:32]);
          check(wr_data == e[31:0], "R4 beat data byte order", wr_data, e[31:0]);
        end
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic run_sweep(input logic [31:0] b, input int h, input int v,
                           input int rix, input bit fast, input bit poke,
                           input logic [31:0] exp_last);
    logic [31:0] r;
    base = b; hl = h; vl = v; ex = 0; ey = 0; launches = 0;
    runaway_idx = rix; fast_ready = fast;
    cfg_write(3'd1, b);
    cfg_write(3'd2, 32'(h));
    cfg_write(3'd3, 32'(v));
    cfg_write(3'd0, 32'd1);
    cfg_read(3'd0, r);
    check(r == 32'd1, "R1 busy visible in control", r, 32'd1);
    if (poke) begin
      while (launches < 2) @(negedge clk);
      cfg_write(3'd0, 32'd1);   // R9: start while busy
      check(busy, "R9 still busy after second start", 32'(busy), 32'd1);
    end
    while (!irq) @(negedge clk);
    check(!busy, "R8 busy low with irq", 32'(busy), 32'd0);
    check(launches == (h + 1) * (v + 1), "R9 launch count",
          32'(launches), 32'((h + 1) * (v + 1)));
    check(exp_q.size() == 0, "R5 all beats done before irq",
          32'(exp_q.size()), 32'd0);
    @(negedge clk);
    check(!irq, "R8 irq single cycle", 32'(irq), 32'd0);
    cfg_read(3'd4, r);
    check(r == 32'((h + 1) * (v + 1)), "R8 vertex count", r, 32'((h + 1) * (v + 1)));
    cfg_read(3'd5, r);
    check(r == exp_last, "R6 last write address", r, exp_last);
  endtask

  initial begin
    logic [31:0] r;
    active = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check(!busy && !irq && !wr_valid, "R10 outputs after reset",
          {29'd0, busy, irq, wr_valid}, 32'd0);
    cfg_read(3'd4, r);
    check(r == 32'd0, "R10 vertex count after reset", r, 32'd0);
    cfg_read(3'd5, r);
    check(r == 32'd0, "R10 last write after reset", r, 32'd0);
    cfg_read(3'd0, r);
    check(r == 32'd0, "R10 control after reset", r, 32'd0);

    // 3x2 mesh, stalls, runaway at (1,1), extra start mid-sweep
    run_sweep(32'h1000_0000, 2, 1, 4, 1'b0, 1'b1, 32'h1000_0000 + 32'd1044);
    // single vertex, no stalls
    run_sweep(32'h0002_0000, 0, 0, -1, 1'b1, 1'b0, 32'h0002_0004);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule